// File: doc/BRIEF.md
# Parallel flash programming controller

This block is the device-side engine of a parallel programming port on a flash microcontroller. An external programmer presents a 4-bit mode code, a 14-bit address (6 upper and 8 lower bits), an 8-bit data byte and an active-low program strobe. The block synchronises the strobe and counts how many clock cycles it stays low. When the strobe rises again, the block runs the command that was captured at the falling edge. It does this only if the low time suits that command.

The state it manages consists of a parameterised program array, an encryption array, three cumulative lock bits and a watchdog power-on option bit. Write-type commands are mass erase, byte program, encryption write, the three lock-bit levels, option write and option erase. Read-type commands are byte read, lock-bit read and identification read. Read-type commands never use the strobe. While the strobe is high they drive a combinational data byte and raise an output enable. A write pulse whose width is rejected leaves every piece of state as it was and raises an error flag.

Top module: `pflash_ctrl`

## Requirements
- R1: After reset, every program location reads FFh, the lock-bit read gives FFh, the option bit equals OPT_INIT and err_o is 0.
- R2: The mode code is taken with mode_i[0] as the first pin through mode_i[3] as the last. The codes are: 0001 erase, 1110 program, 1100 read byte, 1010 encryption write, 1111 LB1, 0011 LB2, 0101 LB3, 1000 lock read, 0010 option write, 1001 option erase, 0000 ID read. Every other code is unassigned.
- R3: Mass erase runs only when the strobe low time is at least ERASE_CYC cycles. It returns every program and encryption byte to FFh and every lock bit to 1. It leaves the option bit unchanged.
- R4: Byte program accepts a low time from 1 to PROG_MAX_CYC cycles and stores old AND din. An address at or above PROG_DEPTH changes nothing, and reading such an address gives FFh.
- R5: The lock bits are cumulative. LB1 clears bit 0, LB2 clears bits 1:0, and LB3 clears bits 2:0. A lock read returns {5'b11111, LB3, LB2, LB1}. Only mass erase sets a lock bit back to 1.
- R6: An ID read returns MFG_ID at 30h, DEV_ID at 31h, DEV_EXT at 60h, and the option byte {4'hF, wdt, 3'b111} at FCh. It returns FFh at any other address.
- R7: Option write (short pulse) sets the option bit to din[3]. Option erase (pulse of at least ERASE_CYC) clears the option bit to 0.
- R8: A write-type command whose low time is outside its window changes no state and sets err_o. The next accepted write-type command clears err_o.
- R9: Encryption write follows the short-pulse window and stores old AND din. It never alters the program array.
- R10: dout_oe_o is 1 only while the live mode is a read type and the strobe is high. A strobe pulse under a read-type or unassigned code changes no state and leaves err_o unchanged.
- R11: Mode, address and data are captured when the synchronised strobe falls. Changes to them while the strobe stays low do not affect the command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_i | input | 4 | Mode code, bit 0 is the first pin |
| addr_hi_i | input | 6 | Upper address bits 13:8 |
| addr_lo_i | input | 8 | Lower address bits 7:0 |
| din_i | input | 8 | Write data |
| prog_n_i | input | 1 | Active-low program strobe, idles high |
| dout_o | output | 8 | Read data for the live mode and address |
| dout_oe_o | output | 1 | Output enable for dout_o |
| err_o | output | 1 | Rejected pulse-width flag |

## Verification
The assertions assume that mode, address and data are valid by the time the synchronised strobe falls, which is two clock cycles after the pin falls. They also assume that every strobe pulse and every gap between pulses spans at least a few cycles, so that each fall and rise edge is seen. The stimulus changes inputs only one nanosecond after a rising clock edge. It sets them in the same step as the strobe fall and changes them mid-pulse only in the capture test, well after the fall has been registered. After each rise it waits six cycles, so every command has landed before the next stimulus or readback.

// File: rtl/pfp_pkg.sv
package pfp_pkg;

  typedef enum logic [3:0] {
    C_NONE, C_ERASE, C_PROG, C_READ, C_ENC, C_LB1, C_LB2, C_LB3,
    C_RDLOCK, C_WROPT, C_EROPT, C_RDID
  } cmd_e;

  // mode[0] is the first pin, mode[3] the last
  function automatic cmd_e mode_to_cmd(input logic [3:0] mode);
    case (mode)
      4'b0001: return C_ERASE;
      4'b1110: return C_PROG;
      4'b1100: return C_READ;
      4'b1010: return C_ENC;
      4'b1111: return C_LB1;
      4'b0011: return C_LB2;
      4'b0101: return C_LB3;
      4'b1000: return C_RDLOCK;
      4'b0010: return C_WROPT;
      4'b1001: return C_EROPT;
      4'b0000: return C_RDID;
      default: return C_NONE;
    endcase
  endfunction

  function automatic logic is_read(input cmd_e c);
    return (c == C_READ) || (c == C_RDLOCK) || (c == C_RDID);
  endfunction

  function automatic logic is_write(input cmd_e c);
    return (c != C_NONE) && !is_read(c);
  endfunction

  function automatic logic is_long(input cmd_e c);
    return (c == C_ERASE) || (c == C_EROPT);
  endfunction

  // Pulse acceptance window for a command class
  function automatic logic width_ok(input logic long_req, input int unsigned len,
                                    input int unsigned long_min,
                                    input int unsigned short_max);
    if (long_req) return len >= long_min;
    return (len != 0) && (len <= short_max);
  endfunction

  // Lock state is {LB3, LB2, LB1}; a level clears itself and every lower bit
  function automatic logic [2:0] lock_after(input cmd_e c, input logic [2:0] lb);
    case (c)
      C_LB1:   return lb & 3'b110;
      C_LB2:   return lb & 3'b100;
      C_LB3:   return 3'b000;
      default: return lb;
    endcase
  endfunction

  function automatic logic [7:0] lock_byte(input logic [2:0] lb);
    return {5'b11111, lb};
  endfunction

  function automatic logic [7:0] opt_byte(input logic wdt);
    return {4'hF, wdt, 3'b111};
  endfunction

endpackage

// File: rtl/pfp_decode.sv
module pfp_decode
  import pfp_pkg::*;
(
  input  logic [3:0] mode_i,
  output cmd_e       cmd_o
);
  always_comb cmd_o = mode_to_cmd(mode_i);
endmodule

// File: rtl/pfp_strobe.sv
module pfp_strobe #(
  parameter int unsigned CNT_MAX = 40,
  parameter int unsigned CW      = $clog2(CNT_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          strobe_n_i,
  output logic          fall_o,
  output logic          rise_o,
  output logic          low_o,
  output logic [CW-1:0] len_o
);
  localparam logic [CW-1:0] SAT = CW'(CNT_MAX);

  logic [2:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= 3'b111;
    else        sh <= {sh[1:0], strobe_n_i};
  end

  assign low_o  = ~sh[1];
  assign fall_o =  sh[2] & ~sh[1];
  assign rise_o = ~sh[2] &  sh[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       len_o <= '0;
    else if (fall_o)                  len_o <= CW'(1);
    else if (low_o && len_o != SAT)   len_o <= len_o + 1'b1;
  end

  // R8: low time advances by one per low cycle until saturation
  a_r8_len_counts: assert property (@(posedge clk) disable iff (!rst_n)
    (low_o && !fall_o && len_o != SAT) |=> (len_o == $past(len_o) + 1'b1));

  a_r8_len_holds_high: assert property (@(posedge clk) disable iff (!rst_n)
    (!low_o && !fall_o) |=> $stable(len_o) || fall_o);

endmodule

// File: rtl/pfp_store.sv
module pfp_store
  import pfp_pkg::*;
#(
  parameter int unsigned ADDR_W     = 14,
  parameter int unsigned PROG_DEPTH = 256,
  parameter int unsigned ENC_DEPTH  = 64,
  parameter logic [7:0]  MFG_ID     = 8'h4D,
  parameter logic [7:0]  DEV_ID     = 8'h52,
  parameter logic [7:0]  DEV_EXT    = 8'h01,
  parameter logic        OPT_INIT   = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              exec_i,
  input  cmd_e              cmd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        din_i,
  input  cmd_e              rd_cmd_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [7:0]        dout_o
);
  localparam int unsigned IDX_W  = $clog2(PROG_DEPTH);
  localparam int unsigned EIDX_W = $clog2(ENC_DEPTH);
  localparam logic [ADDR_W:0] PROG_LIM = (ADDR_W + 1)'(PROG_DEPTH);
  localparam logic [ADDR_W:0] ENC_LIM  = (ADDR_W + 1)'(ENC_DEPTH);

  logic [7:0] mem [PROG_DEPTH];
  logic [7:0] enc [ENC_DEPTH];
  logic [2:0] lb;
  logic       wdt;

  logic              prog_hit, enc_hit, rd_hit;
  logic [IDX_W-1:0]  widx, ridx;
  logic [EIDX_W-1:0] eidx;
  logic [7:0]        prog_old, enc_old;

  assign prog_hit = {1'b0, addr_i} < PROG_LIM;
  assign enc_hit  = {1'b0, addr_i} < ENC_LIM;
  assign rd_hit   = {1'b0, rd_addr_i} < PROG_LIM;
  assign widx     = addr_i[IDX_W-1:0];
  assign eidx     = addr_i[EIDX_W-1:0];
  assign ridx     = rd_addr_i[IDX_W-1:0];
  assign prog_old = mem[widx];
  assign enc_old  = enc[eidx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < PROG_DEPTH; i++) mem[i] <= 8'hFF;
      for (int j = 0; j < ENC_DEPTH; j++)  enc[j] <= 8'hFF;
      lb  <= 3'b111;
      wdt <= OPT_INIT;
    end else if (exec_i) begin
      case (cmd_i)
        C_ERASE: begin
          for (int i = 0; i < PROG_DEPTH; i++) mem[i] <= 8'hFF;
          for (int j = 0; j < ENC_DEPTH; j++)  enc[j] <= 8'hFF;
          lb <= 3'b111;
        end
        C_PROG:  if (prog_hit) mem[widx] <= prog_old & din_i;
        C_ENC:   if (enc_hit)  enc[eidx] <= enc_old & din_i;
        C_LB1, C_LB2, C_LB3: lb <= lock_after(cmd_i, lb);
        C_WROPT: wdt <= din_i[3];
        C_EROPT: wdt <= 1'b0;
        default: ;
      endcase
    end
  end

  always_comb begin
    dout_o = 8'hFF;
    case (rd_cmd_i)
      C_READ:   if (rd_hit) dout_o = mem[ridx];
      C_RDLOCK: dout_o = lock_byte(lb);
      C_RDID: begin
        case (rd_addr_i)
          ADDR_W'('h30): dout_o = MFG_ID;
          ADDR_W'('h31): dout_o = DEV_ID;
          ADDR_W'('h60): dout_o = DEV_EXT;
          ADDR_W'('hFC): dout_o = opt_byte(wdt);
          default:       dout_o = 8'hFF;
        endcase
      end
      default: ;
    endcase
  end

  // R3: erase returns security state and the first cells to erased values
  a_r3_erase_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_i && cmd_i == C_ERASE) |=> (lb == 3'b111 && mem[0] == 8'hFF && enc[0] == 8'hFF));

  a_r3_erase_keeps_opt: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_i && cmd_i == C_ERASE) |=> $stable(wdt));

  // R4: programming can only clear bits
  a_r4_prog_and: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_i && cmd_i == C_PROG && prog_hit) |=> (mem[$past(widx)] == $past(prog_old & din_i)));

  // R9: encryption cells follow the same clear-only rule
  a_r9_enc_and: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_i && cmd_i == C_ENC && enc_hit) |=> (enc[$past(eidx)] == $past(enc_old & din_i)));

  // R5: a lock bit may return to 1 only after an erase
  a_r5_lock_no_set: assert property (@(posedge clk) disable iff (!rst_n)
    !(exec_i && cmd_i == C_ERASE) |=> ((lb & ~$past(lb)) == 3'b000));

  // R7: option bit only moves under the two option commands
  a_r7_opt_guarded: assert property (@(posedge clk) disable iff (!rst_n)
    !(exec_i && (cmd_i == C_WROPT || cmd_i == C_EROPT)) |=> $stable(wdt));

endmodule

// File: rtl/pflash_ctrl.sv
module pflash_ctrl
  import pfp_pkg::*;
#(
  parameter int unsigned ADDR_HI_W    = 6,
  parameter int unsigned ADDR_LO_W    = 8,
  parameter int unsigned PROG_DEPTH   = 256,
  parameter int unsigned ENC_DEPTH    = 64,
  parameter int unsigned ERASE_CYC    = 40,
  parameter int unsigned PROG_MAX_CYC = 20,
  parameter logic [7:0]  MFG_ID       = 8'h4D,
  parameter logic [7:0]  DEV_ID       = 8'h52,
  parameter logic [7:0]  DEV_EXT      = 8'h01,
  parameter logic        OPT_INIT     = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [3:0]           mode_i,
  input  logic [ADDR_HI_W-1:0] addr_hi_i,
  input  logic [ADDR_LO_W-1:0] addr_lo_i,
  input  logic [7:0]           din_i,
  input  logic                 prog_n_i,
  output logic [7:0]           dout_o,
  output logic                 dout_oe_o,
  output logic                 err_o
);
  localparam int unsigned ADDR_W  = ADDR_HI_W + ADDR_LO_W;
  localparam int unsigned CNT_MAX = (ERASE_CYC > PROG_MAX_CYC) ? ERASE_CYC : PROG_MAX_CYC + 1;
  localparam int unsigned CW      = $clog2(CNT_MAX + 1);

  logic              st_fall, st_rise, st_low;
  logic [CW-1:0]     st_len;
  logic [3:0]        cap_mode;
  logic [ADDR_W-1:0] cap_addr, live_addr;
  logic [7:0]        cap_din;
  cmd_e              cap_cmd, live_cmd;
  logic              pulse_ok, do_write, exec_v, reject_v;

  assign live_addr = {addr_hi_i, addr_lo_i};

  pfp_strobe #(.CNT_MAX(CNT_MAX), .CW(CW)) u_strobe (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe_n_i (prog_n_i),
    .fall_o     (st_fall),
    .rise_o     (st_rise),
    .low_o      (st_low),
    .len_o      (st_len)
  );

  // command operands are frozen at the synchronised falling edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_mode <= 4'b0100;
      cap_addr <= '0;
      cap_din  <= 8'hFF;
    end else if (st_fall) begin
      cap_mode <= mode_i;
      cap_addr <= live_addr;
      cap_din  <= din_i;
    end
  end

  pfp_decode u_cap_dec  (.mode_i(cap_mode), .cmd_o(cap_cmd));
  pfp_decode u_live_dec (.mode_i(mode_i),   .cmd_o(live_cmd));

  assign pulse_ok = width_ok(is_long(cap_cmd), 32'(st_len), ERASE_CYC, PROG_MAX_CYC);
  assign do_write = st_rise && is_write(cap_cmd);
  assign exec_v   = do_write && pulse_ok;
  assign reject_v = do_write && !pulse_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        err_o <= 1'b0;
    else if (reject_v) err_o <= 1'b1;
    else if (exec_v)   err_o <= 1'b0;
  end

  pfp_store #(
    .ADDR_W     (ADDR_W),
    .PROG_DEPTH (PROG_DEPTH),
    .ENC_DEPTH  (ENC_DEPTH),
    .MFG_ID     (MFG_ID),
    .DEV_ID     (DEV_ID),
    .DEV_EXT    (DEV_EXT),
    .OPT_INIT   (OPT_INIT)
  ) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .exec_i    (exec_v),
    .cmd_i     (cap_cmd),
    .addr_i    (cap_addr),
    .din_i     (cap_din),
    .rd_cmd_i  (live_cmd),
    .rd_addr_i (live_addr),
    .dout_o    (dout_o)
  );

  assign dout_oe_o = is_read(live_cmd) && prog_n_i;

  // R3: long commands only run after a full-length low time
  a_r3_long_needs_len: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_v && is_long(cap_cmd)) |-> (32'(st_len) >= ERASE_CYC));

  // R8: a rejected pulse leaves the flag raised
  a_r8_reject_flags: assert property (@(posedge clk) disable iff (!rst_n)
    reject_v |=> err_o);

  // R10: the flag moves only on a write-type rise
  a_r10_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !do_write |=> $stable(err_o));

  // R11: captured operands hold while the strobe stays low
  a_r11_cap_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (st_low && !st_fall) |=> ($stable(cap_mode) && $stable(cap_addr) && $stable(cap_din)));

endmodule

// File: tb/pflash_ctrl_test.sv
module pflash_ctrl_test;
  localparam int ERASE_CYC = 40;
  localparam int PROG_MAX  = 20;

  localparam logic [3:0] M_ERASE = 4'b0001, M_PROG = 4'b1110, M_READ = 4'b1100,
                         M_ENC   = 4'b1010, M_LB1  = 4'b1111, M_LB2  = 4'b0011,
                         M_LB3   = 4'b0101, M_RDLK = 4'b1000, M_WOPT = 4'b0010,
                         M_EOPT  = 4'b1001, M_RDID = 4'b0000, M_FREE = 4'b0100;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] mode = M_READ;
  logic [5:0] addr_hi = '0;
  logic [7:0] addr_lo = '0;
  logic [7:0] din = 8'hFF;
  logic       prog_n = 1'b1;
  logic [7:0] dout;
  logic       dout_oe, err;

  always #5 clk = ~clk;

  pflash_ctrl #(
    .ERASE_CYC(ERASE_CYC), .PROG_MAX_CYC(PROG_MAX),
    .MFG_ID(8'h4D), .DEV_ID(8'h52), .DEV_EXT(8'h01), .OPT_INIT(1'b1)
  ) uut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .addr_hi_i(addr_hi), .addr_lo_i(addr_lo),
    .din_i(din), .prog_n_i(prog_n), .dout_o(dout), .dout_oe_o(dout_oe), .err_o(err)
  );

  typedef struct {
    logic       is_err;
    logic [7:0] exp_d;
    logic       exp_oe;
    logic       exp_err;
    string      tag;
  } item_t;

  item_t sb[$];
  int checks = 0;
  int fails  = 0;

  // monitor: compare one expected item per falling edge
  always @(negedge clk) begin
    item_t it;
    if (sb.size() > 0) begin
      it = sb.pop_front();
      checks++;
      if (it.is_err) begin
        if (err !== it.exp_err) begin
          fails++;
          $display("FAIL %s: err_o=%b expected %b", it.tag, err, it.exp_err);
        end
      end else if (dout_oe !== it.exp_oe || (it.exp_oe && dout !== it.exp_d)) begin
        fails++;
        $display("FAIL %s: dout=%h oe=%b expected dout=%h oe=%b",
                 it.tag, dout, dout_oe, it.exp_d, it.exp_oe);
      end
    end
  end

  task automatic drain();
    while (sb.size() > 0) @(posedge clk);
  endtask

  task automatic expect_rd(input logic [3:0] m, input logic [13:0] a,
                           input logic [7:0] d, input logic oe, input string tag);
    @(posedge clk); #1;
    mode = m; addr_hi = a[13:8]; addr_lo = a[7:0];
    sb.push_back('{is_err: 1'b0, exp_d: d, exp_oe: oe, exp_err: 1'b0, tag: tag});
    drain();
  endtask

  task automatic expect_err(input logic e, input string tag);
    @(posedge clk); #1;
    sb.push_back('{is_err: 1'b1, exp_d: 8'h00, exp_oe: 1'b0, exp_err: e, tag: tag});
    drain();
  endtask

  task automatic pulse(input logic [3:0] m, input logic [13:0] a, input logic [7:0] d,
                       input int n);
    @(posedge clk); #1;
    mode = m; addr_hi = a[13:8]; addr_lo = a[7:0]; din = d; prog_n = 1'b0;
    repeat (n) @(posedge clk);
    #1 prog_n = 1'b1;
    repeat (6) @(posedge clk);
  endtask

  function automatic logic [7:0] opt_rd(input logic w);
    return {4'hF, w, 3'b111};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    expect_err(1'b0, "R1");
    expect_rd(M_READ, 14'h000, 8'hFF, 1'b1, "R1");
    expect_rd(M_READ, 14'h0FF, 8'hFF, 1'b1, "R1");
    expect_rd(M_RDLK, 14'h040, 8'hFF, 1'b1, "R1");
    expect_rd(M_RDID, 14'h0FC, opt_rd(1'b1), 1'b1, "R1");
    // R10 write mode, strobe high: no enable
    expect_rd(M_PROG, 14'h000, 8'hFF, 1'b0, "R10");

    // R4 program and AND rule; R2 read code
    pulse(M_PROG, 14'h005, 8'hA5, 5);
    expect_rd(M_READ, 14'h005, 8'hA5, 1'b1, "R4");
    pulse(M_PROG, 14'h005, 8'h0F, 5);
    expect_rd(M_READ, 14'h005, 8'h05, 1'b1, "R4");
    pulse(M_PROG, 14'h100, 8'h00, 5);
    expect_rd(M_READ, 14'h100, 8'hFF, 1'b1, "R4");
    expect_rd(M_READ, 14'h000, 8'hFF, 1'b1, "R4");
    pulse(M_PROG, 14'h007, 8'h3C, PROG_MAX);
    expect_rd(M_READ, 14'h007, 8'h3C, 1'b1, "R4");

    // R8 too long program pulse
    pulse(M_PROG, 14'h008, 8'h00, PROG_MAX + 1);
    expect_rd(M_READ, 14'h008, 8'hFF, 1'b1, "R8");
    expect_err(1'b1, "R8");
    pulse(M_PROG, 14'h009, 8'h77, 3);
    expect_err(1'b0, "R8");
    expect_rd(M_READ, 14'h009, 8'h77, 1'b1, "R8");

    // R6 identification reads
    expect_rd(M_RDID, 14'h030, 8'h4D, 1'b1, "R6");
    expect_rd(M_RDID, 14'h031, 8'h52, 1'b1, "R6");
    expect_rd(M_RDID, 14'h060, 8'h01, 1'b1, "R6");
    expect_rd(M_RDID, 14'h055, 8'hFF, 1'b1, "R6");

    // R5 cumulative lock bits; R10 pulse under read code
    pulse(M_LB1, 14'h000, 8'hFF, 4);
    expect_rd(M_RDLK, 14'h040, 8'hFE, 1'b1, "R5");
    pulse(M_LB2, 14'h000, 8'hFF, 4);
    expect_rd(M_RDLK, 14'h040, 8'hFC, 1'b1, "R5");
    pulse(M_RDLK, 14'h040, 8'hFF, 4);
    expect_rd(M_RDLK, 14'h040, 8'hFC, 1'b1, "R10");
    expect_err(1'b0, "R10");
    pulse(M_LB1, 14'h000, 8'hFF, 4);
    expect_rd(M_RDLK, 14'h040, 8'hFC, 1'b1, "R5");
    pulse(M_LB3, 14'h000, 8'hFF, 4);
    expect_rd(M_RDLK, 14'h040, 8'hF8, 1'b1, "R5");

    // R7 option write and erase; R8 short erase
    pulse(M_WOPT, 14'h000, 8'h00, 4);
    expect_rd(M_RDID, 14'h0FC, opt_rd(1'b0), 1'b1, "R7");
    pulse(M_WOPT, 14'h000, 8'h08, 4);
    expect_rd(M_RDID, 14'h0FC, opt_rd(1'b1), 1'b1, "R7");
    pulse(M_EOPT, 14'h000, 8'hFF, ERASE_CYC - 1);
    expect_rd(M_RDID, 14'h0FC, opt_rd(1'b1), 1'b1, "R8");
    expect_err(1'b1, "R8");
    pulse(M_EOPT, 14'h000, 8'hFF, ERASE_CYC);
    expect_rd(M_RDID, 14'h0FC, opt_rd(1'b0), 1'b1, "R7");
    expect_err(1'b0, "R7");

    // R9 encryption write does not reach program array
    pulse(M_ENC, 14'h005, 8'h00, 4);
    expect_rd(M_READ, 14'h005, 8'h05, 1'b1, "R9");
    expect_err(1'b0, "R9");
    pulse(M_ENC, 14'h006, 8'h00, PROG_MAX + 1);
    expect_err(1'b1, "R9");
    pulse(M_ENC, 14'h006, 8'h00, 2);
    expect_err(1'b0, "R9");

    // R11 operands captured at the fall
    @(posedge clk); #1;
    mode = M_PROG; addr_hi = 6'h00; addr_lo = 8'h0A; din = 8'h12; prog_n = 1'b0;
    repeat (5) @(posedge clk);
    #1 addr_lo = 8'h0B; din = 8'h00; mode = M_LB3;
    repeat (5) @(posedge clk);
    #1 prog_n = 1'b1;
    repeat (6) @(posedge clk);
    expect_rd(M_READ, 14'h00A, 8'h12, 1'b1, "R11");
    expect_rd(M_READ, 14'h00B, 8'hFF, 1'b1, "R11");
    expect_rd(M_RDLK, 14'h040, 8'hF8, 1'b1, "R11");

    // R3 mass erase window and effect
    pulse(M_ERASE, 14'h000, 8'hFF, ERASE_CYC - 1);
    expect_rd(M_READ, 14'h005, 8'h05, 1'b1, "R3");
    expect_err(1'b1, "R3");
    pulse(M_ERASE, 14'h000, 8'hFF, ERASE_CYC);
    expect_rd(M_READ, 14'h005, 8'h05 | 8'hFF, 1'b1, "R3");
    expect_rd(M_READ, 14'h00A, 8'hFF, 1'b1, "R3");
    expect_rd(M_RDLK, 14'h040, 8'hFF, 1'b1, "R3");
    expect_rd(M_RDID, 14'h0FC, opt_rd(1'b0), 1'b1, "R3");
    expect_err(1'b0, "R3");

    // R2 unassigned code: no effect, no flag, no enable
    pulse(M_FREE, 14'h003, 8'h00, 4);
    expect_err(1'b0, "R2");
    expect_rd(M_FREE, 14'h003, 8'hFF, 1'b0, "R2");
    expect_rd(M_READ, 14'h003, 8'hFF, 1'b1, "R2");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule